// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small programmable logic device. It takes a fixed group of product terms from the AND array and ORs them into one sum. A polarity bit then XORs the sum, so the result can be active high or active low. The result either goes through a rising-edge D flip-flop or passes straight to the pin. The cell produces a pin value with a separate tristate enable, and it returns one feedback signal to the input matrix.

Static configuration inputs select how the cell behaves. A two-bit mode field sets up the output path, the enable and the feedback path together. Code 00 is registered mode, 01 is combinational mode, and 10 or 11 is dedicated-input mode. A two-bit enable code selects the tristate control. A one-bit feedback select picks the feedback source within the current mode. The flip-flop clears to 0 on an asynchronous active-low reset.

Top module: `out_macrocell`

## Requirements
- R1: The sum is the OR of all product terms. When the enable code is 01, term bit 0 is left out of the sum.
- R2: With the polarity bit at 1, the result is the complement of the sum. With the polarity bit at 0, it equals the sum.
- R3: In registered mode (mode 00), `pin_out` equals the polarity-adjusted sum captured at the previous rising clock edge. Reset clears the flip-flop to 0.
- R4: In combinational mode (mode 01), `pin_out` equals the polarity-adjusted sum in the same cycle, with no clock edge between.
- R5: In modes 00 and 01, the enable code selects `pin_oe` as follows: 11 gives constant 1, 10 gives `glb_oe`, 01 gives product term bit 0, and 00 gives constant 0.
- R6: In dedicated-input mode (mode 10 or 11), `pin_oe` is 0 and `pin_out` is 0, whatever the enable code and the terms.
- R7: In registered mode, `fb_out` is the inverse of the flip-flop output, whatever the feedback select.
- R8: In combinational mode, `fb_out` is the polarity-adjusted sum when the feedback select is 0, and `pin_in` when it is 1.
- R9: In dedicated-input mode, `fb_out` is `pin_in` when the feedback select is 0, and `adj_in` (the neighbouring cell's output) when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for the flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| pterm | input | NUM_TERMS | Product terms from the AND array |
| glb_oe | input | 1 | Global output-enable pin |
| pin_in | input | 1 | Value currently present on the cell's pad |
| adj_in | input | 1 | Output of the neighbouring cell |
| cfg_mode | input | 2 | Mode: 00 registered, 01 combinational, 1x dedicated input |
| cfg_invert | input | 1 | Polarity bit: 1 inverts the sum |
| cfg_oe_sel | input | 2 | Enable code, as described in R5 |
| cfg_fb_sel | input | 1 | Feedback select within the current mode |
| pin_out | output | 1 | Data value for the pad driver |
| pin_oe | output | 1 | Tristate enable for the pad driver |
| fb_out | output | 1 | Feedback to the input matrix |

## Verification
Every path is combinational except the registered one. The enable, the combinational-mode pin and every feedback choice except R7 must therefore hold 1 ns after inputs change at a falling edge. The registered pin and its inverted feedback must hold only after the next rising edge.

The bench drives each stimulus at a falling edge and checks the combinational results 1 ns later. It holds the inputs through one rising edge, then checks all outputs again at the following falling edge. At that point the flip-flop holds the sum of that same stimulus.

The sweep covers every configuration against all 256 term patterns. The checker compares the registered pin with the sum sampled one edge earlier.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_REG       = 2'b00,
        MODE_COMB      = 2'b01,
        MODE_INPUT     = 2'b10,
        MODE_INPUT_ALT = 2'b11
    } mode_t;

    typedef enum logic [1:0] {
        OE_NEVER  = 2'b00,
        OE_TERM0  = 2'b01,
        OE_GLOBAL = 2'b10,
        OE_ALWAYS = 2'b11
    } oe_t;

    function automatic logic is_input_mode(input mode_t m);
        return (m == MODE_INPUT) || (m == MODE_INPUT_ALT);
    endfunction

endpackage

// File: rtl/mc_term_sum.sv
module mc_term_sum #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic                 drop_first,
    input  logic                 invert,
    output logic                 result
);
    logic sum;

    generate
        if (NUM_TERMS > 1) begin : g_multi
            localparam int UPPER = NUM_TERMS - 1;
            logic [UPPER-1:0] rest;
            assign rest = pterm[NUM_TERMS-1:1];
            always_comb begin
                sum = (|rest) | (pterm[0] & ~drop_first);
            end
        end else begin : g_single
            always_comb begin
                sum = pterm[0] & ~drop_first;
            end
        end
    endgenerate

    always_comb begin
        result = sum ^ invert;
    end
endmodule

// File: rtl/mc_dff.sv
module mc_dff (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mc_oe_mux.sv
module mc_oe_mux
    import mc_pkg::*;
(
    input  mode_t mode,
    input  oe_t   code,
    input  logic  glb_oe,
    input  logic  term0,
    output logic  oe
);
    always_comb begin
        if (is_input_mode(mode)) begin
            oe = 1'b0;
        end else begin
            unique case (code)
                OE_ALWAYS: oe = 1'b1;
                OE_GLOBAL: oe = glb_oe;
                OE_TERM0:  oe = term0;
                OE_NEVER:  oe = 1'b0;
                default:   oe = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mc_fb_mux.sv
module mc_fb_mux
    import mc_pkg::*;
(
    input  mode_t mode,
    input  logic  fb_sel,
    input  logic  q,
    input  logic  comb,
    input  logic  pin_in,
    input  logic  adj_in,
    output logic  fb
);
    always_comb begin
        unique case (mode)
            MODE_REG:       fb = ~q;
            MODE_COMB:      fb = fb_sel ? pin_in : comb;
            MODE_INPUT,
            MODE_INPUT_ALT: fb = fb_sel ? adj_in : pin_in;
            default:        fb = 1'b0;
        endcase
    end
endmodule

// File: rtl/out_macrocell.sv
module out_macrocell #(
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic                 glb_oe,
    input  logic                 pin_in,
    input  logic                 adj_in,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_invert,
    input  logic [1:0]           cfg_oe_sel,
    input  logic                 cfg_fb_sel,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_out
);
    import mc_pkg::*;

    mode_t mode;
    oe_t   oe_code;
    logic  drop_first;
    logic  comb_val;
    logic  reg_q;

    assign mode       = mode_t'(cfg_mode);
    assign oe_code    = oe_t'(cfg_oe_sel);
    assign drop_first = (oe_code == OE_TERM0);

    mc_term_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .pterm      (pterm),
        .drop_first (drop_first),
        .invert     (cfg_invert),
        .result     (comb_val)
    );

    mc_dff u_dff (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (comb_val),
        .q     (reg_q)
    );

    mc_oe_mux u_oe (
        .mode   (mode),
        .code   (oe_code),
        .glb_oe (glb_oe),
        .term0  (pterm[0]),
        .oe     (pin_oe)
    );

    mc_fb_mux u_fb (
        .mode   (mode),
        .fb_sel (cfg_fb_sel),
        .q      (reg_q),
        .comb   (comb_val),
        .pin_in (pin_in),
        .adj_in (adj_in),
        .fb     (fb_out)
    );

    always_comb begin
        unique case (mode)
            MODE_REG:       pin_out = reg_q;
            MODE_COMB:      pin_out = comb_val;
            MODE_INPUT,
            MODE_INPUT_ALT: pin_out = 1'b0;
            default:        pin_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/out_macrocell_chk.sv
module out_macrocell_chk #(
    parameter int NUM_TERMS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_TERMS-1:0] pterm,
    input logic                 glb_oe,
    input logic                 pin_in,
    input logic                 adj_in,
    input logic [1:0]           cfg_mode,
    input logic                 cfg_invert,
    input logic [1:0]           cfg_oe_sel,
    input logic                 cfg_fb_sel,
    input logic                 pin_out,
    input logic                 pin_oe,
    input logic                 fb_out
);
    logic [NUM_TERMS-1:0] keep;
    logic                 want;

    always_comb begin
        keep = '1;
        if (cfg_oe_sel == 2'b01) keep[0] = 1'b0;
        want = (|(pterm & keep)) ^ cfg_invert;
    end

    // R3
    reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_mode == 2'b00) |-> (pin_out == $past(want)));

    // R4
    comb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01) |-> (pin_out == want));

    // R6
    input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1]) |-> (!pin_oe && !pin_out));

    // R5
    oe_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode[1] && cfg_oe_sel == 2'b10) |-> (pin_oe == glb_oe));

    // R5
    oe_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode[1] && cfg_oe_sel == 2'b01) |-> (pin_oe == pterm[0]));

    // R7
    reg_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00) |-> (fb_out == !pin_out));

    // R8
    comb_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01) |-> (fb_out == (cfg_fb_sel ? pin_in : pin_out)));

    // R9
    input_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1]) |-> (fb_out == (cfg_fb_sel ? adj_in : pin_in)));
endmodule

bind out_macrocell out_macrocell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (.*);

// File: tb/test_out_macrocell.sv
module test_out_macrocell;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] pterm = '1;
    logic          glb_oe = 1'b0;
    logic          pin_in = 1'b0;
    logic          adj_in = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cfg_invert = 1'b0;
    logic [1:0]    cfg_oe_sel = 2'b11;
    logic          cfg_fb_sel = 1'b0;
    logic          pin_out, pin_oe, fb_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    out_macrocell #(.NUM_TERMS(NT)) i_out_macrocell (
        .clk(clk), .rst_n(rst_n), .pterm(pterm), .glb_oe(glb_oe),
        .pin_in(pin_in), .adj_in(adj_in), .cfg_mode(cfg_mode),
        .cfg_invert(cfg_invert), .cfg_oe_sel(cfg_oe_sel),
        .cfg_fb_sel(cfg_fb_sel), .pin_out(pin_out), .pin_oe(pin_oe),
        .fb_out(fb_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d inv=%0d oe=%0d fb=%0d terms=%h actual=%b expected=%b",
                     tag, cfg_mode, cfg_invert, cfg_oe_sel, cfg_fb_sel, pterm, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R3: reset state of the flop, seen through registered mode
        repeat (3) @(negedge clk);
        #1;
        check("R3 reset pin", pin_out, 1'b0);
        check("R7 reset fb", fb_out, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int oe = 0; oe < 4; oe++) begin
                    for (int fs = 0; fs < 2; fs++) begin
                        for (int t = 0; t < 256; t++) begin
                            logic [7:0] tv;
                            logic sum, pol, exp_oe, exp_pin, exp_fb;
                            tv = 8'(t);
                            @(negedge clk);
                            cfg_mode   = 2'(m);
                            cfg_invert = 1'(inv);
                            cfg_oe_sel = 2'(oe);
                            cfg_fb_sel = 1'(fs);
                            pterm      = tv;
                            glb_oe     = tv[0] ^ tv[7];
                            pin_in     = tv[2] ^ tv[5];
                            adj_in     = tv[1] ^ tv[6];
                            // R1: term 0 dropped when enable code is 01
                            sum = (oe == 1) ? (|tv[7:1]) : (|tv);
                            // R2: polarity
                            pol = sum ^ inv[0];
                            case (oe)
                                3: exp_oe = 1'b1;
                                2: exp_oe = glb_oe;
                                1: exp_oe = tv[0];
                                default: exp_oe = 1'b0;
                            endcase
                            if (m >= 2) begin
                                exp_oe  = 1'b0;
                                exp_pin = 1'b0;
                                exp_fb  = fs ? adj_in : pin_in;
                            end else if (m == 1) begin
                                exp_pin = pol;
                                exp_fb  = fs ? pin_in : pol;
                            end else begin
                                exp_pin = pol;
                                exp_fb  = ~pol;
                            end
                            #1;
                            // same-cycle results
                            if (m == 1) begin
                                check(inv ? "R2 comb pin" : "R4 comb pin", pin_out, exp_pin);
                                check("R8 comb fb", fb_out, exp_fb);
                            end
                            if (m >= 2) begin
                                check("R6 input oe", pin_oe, 1'b0);
                                check("R9 input fb", fb_out, exp_fb);
                            end else begin
                                check("R5 oe", pin_oe, exp_oe);
                            end
                            // after one rising edge
                            @(negedge clk);
                            #1;
                            if (m == 0) begin
                                check(oe == 1 ? "R1 reg pin" : "R3 reg pin", pin_out, exp_pin);
                                check("R7 reg fb", fb_out, exp_fb);
                            end else if (m == 1) begin
                                check(oe == 1 ? "R1 comb pin" : "R4 comb pin", pin_out, exp_pin);
                            end else begin
                                check("R6 input pin", pin_out, 1'b0);
                            end
                        end
                    end
                end
            end
        end

        // R3: reset mid-run clears the flop
        @(negedge clk);
        cfg_mode = 2'b00; cfg_invert = 1'b0; cfg_oe_sel = 2'b11; pterm = '1;
        @(negedge clk);
        #1;
        check("R3 loaded", pin_out, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R3 async clear", pin_out, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule